// File: doc/BRIEF.md
# Synchronous Phase-Frequency Detector with Overlap Control

This block compares two streams of rising-edge strobes, one from a reference divider and one from a feedback divider, and turns their timing difference into two pump-control levels. A reference strobe raises `up`; a feedback strobe raises `dn`. Each level stays high until the other side catches up. Once both levels are high, a short timer keeps them high together and then drops both in the same cycle. This enforced overlap means that even perfectly aligned inputs produce a pulse of known width on both outputs. As a result, the detector has no dead zone around zero phase error.

The overlap lasts a number of fast-clock cycles chosen by a 2-bit select input, `ovl_sel`. The four widths come from parameters, with defaults of 1, 2, 3 and 4 cycles for codes 0 to 3. Everything runs on one system clock, and the divider strobes are one clock cycle wide. A third output, `phase_err`, is high whenever exactly one of the two pump levels is high. The time-average of `up` minus `dn` follows both the phase and the frequency difference between the inputs.

Top module: `pfd_antibacklash`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising clock edge) forces `up`, `dn` and `phase_err` low and clears the overlap timer.
- R2: A `ref_edge` strobe sampled at a clock edge drives `up` high from that edge onward. `up` stays high until a common clear occurs.
- R3: A `fb_edge` strobe sampled at a clock edge drives `dn` high from that edge onward. `dn` stays high until a common clear occurs.
- R4: Once `up` and `dn` are both high, they stay high together for exactly W clock cycles and then both fall at the same edge. W is 1, 2, 3 or 4 for `ovl_sel` codes 0, 1, 2 and 3 (default parameters).
- R5: Strobes on both inputs in the same cycle (zero phase error) still give a pulse of exactly W cycles on both `up` and `dn`, and `phase_err` stays low.
- R6: `phase_err` is high in exactly those cycles where one, and only one, of `up` and `dn` is high.
- R7: A strobe sampled at the clearing edge (the W-th edge after both went high) is ignored. A strobe sampled one edge later sets its output again.
- R8: When the feedback strobe trails the reference strobe by d cycles, `up` is high for d+W cycles and `dn` for W cycles; a lead of d gives the mirror image. Under a steady frequency difference, the faster input's output is high for more cycles in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_edge | input | 1 | One-cycle strobe marking a reference-divider rising edge |
| fb_edge | input | 1 | One-cycle strobe marking a feedback-divider rising edge |
| ovl_sel | input | 2 | Overlap-width code; must not change while both outputs are high |
| up | output | 1 | Pump-up request |
| dn | output | 1 | Pump-down request |
| phase_err | output | 1 | High while exactly one of `up` and `dn` is high |

## Verification
The assertions assume two things about the inputs. First, `ovl_sel` holds steady for the whole of an overlap; the timer compares its count against the width the code selects, so a code change mid-pulse would make the pulse length undefined. Second, each strobe is a single cycle wide. The stimulus changes `ovl_sel` only between episodes, after both outputs have been seen low. It drives each strobe for exactly one cycle at falling edges. The sweep covers every code and every lead and lag from -6 to +6 cycles.

// File: rtl/pfd_pkg.sv
// Package: pfd_pkg
// Shared types and constants for the phase-frequency detector.
// Assumes two channels: index 0 is the reference side, index 1 the feedback side.
package pfd_pkg;
    localparam int unsigned N_CH   = 2;
    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;

    typedef logic [1:0] ovl_sel_t;
endpackage

// File: rtl/pfd_flag.sv
// Module: pfd_flag
// One pump-request flag. Its data input is tied high: a set strobe raises it,
// and a clear request lowers it. A clear takes priority over a set in the
// same cycle, so a strobe that arrives on the clearing edge is dropped.
// Assumes clr_i comes from the shared overlap timer.
module pfd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Flag register: reset, then clear, then set, then hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (clr_i)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> q_o);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o && !clr_i) |=> q_o);
    assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);
endmodule

// File: rtl/pfd_overlap_timer.sv
// Module: pfd_overlap_timer
// Counts the cycles in which both flags are high. It raises the clear
// request in the last cycle of the overlap width chosen by sel_i.
// Assumes sel_i is stable while both_i is high, and that every table
// entry is at least 1.
module pfd_overlap_timer #(
    parameter int unsigned OVL_0 = 1,
    parameter int unsigned OVL_1 = 2,
    parameter int unsigned OVL_2 = 3,
    parameter int unsigned OVL_3 = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             both_i,
    input  pfd_pkg::ovl_sel_t sel_i,
    output logic             clr_o
);
    localparam int unsigned OVL_MAX_A = (OVL_0 > OVL_1) ? OVL_0 : OVL_1;
    localparam int unsigned OVL_MAX_B = (OVL_2 > OVL_3) ? OVL_2 : OVL_3;
    localparam int unsigned OVL_MAX   = (OVL_MAX_A > OVL_MAX_B) ? OVL_MAX_A : OVL_MAX_B;
    localparam int unsigned CNT_W     = $clog2(OVL_MAX + 1);
    localparam logic [3:0][CNT_W-1:0] OVL_TBL =
        {CNT_W'(OVL_3), CNT_W'(OVL_2), CNT_W'(OVL_1), CNT_W'(OVL_0)};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // Terminal count: the overlap width for the current code, minus one.
    always_comb begin
        last_cnt = OVL_TBL[sel_i] - CNT_W'(1);
        clr_o    = both_i && (cnt_q == last_cnt);
    end

    // Count overlap cycles; return to zero on clear or when not overlapping.
    always_ff @(posedge clk) begin
        if (!rst_n || !both_i || clr_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        both_i |-> (cnt_q < OVL_TBL[sel_i]));
    assert_sel_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (both_i && !clr_o) |=> $stable(sel_i));
    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !both_i |=> (cnt_q == '0));
endmodule

// File: rtl/pfd_antibacklash.sv
// Module: pfd_antibacklash
// Top level of the synchronous phase-frequency detector. It holds one flag per
// input (built by a generate loop) and one shared overlap timer that clears
// both flags together. The error pulse is high while the two flags differ.
// Assumes ref_edge and fb_edge are single-cycle strobes in the clk domain.
module pfd_antibacklash #(
    parameter int unsigned OVL_0 = 1,
    parameter int unsigned OVL_1 = 2,
    parameter int unsigned OVL_2 = 3,
    parameter int unsigned OVL_3 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_edge,
    input  logic       fb_edge,
    input  logic [1:0] ovl_sel,
    output logic       up,
    output logic       dn,
    output logic       phase_err
);
    import pfd_pkg::*;

    logic [N_CH-1:0] strobe;
    logic [N_CH-1:0] flag_q;
    logic            both;
    logic            clr;

    // Gather the strobes in channel order and merge the flag states.
    always_comb begin
        strobe[CH_REF] = ref_edge;
        strobe[CH_FB]  = fb_edge;
        both           = &flag_q;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_flag
        pfd_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (strobe[ch]),
            .clr_i (clr),
            .q_o   (flag_q[ch])
        );
    end

    pfd_overlap_timer #(
        .OVL_0 (OVL_0),
        .OVL_1 (OVL_1),
        .OVL_2 (OVL_2),
        .OVL_3 (OVL_3)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .both_i (both),
        .sel_i  (ovl_sel),
        .clr_o  (clr)
    );

    // Drive the pump requests and the error pulse from the flag states.
    always_comb begin
        up        = flag_q[CH_REF];
        dn        = flag_q[CH_FB];
        phase_err = up ^ dn;
    end

    assert_clear_together_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> (up == dn));
    assert_err_quiet_in_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |-> !phase_err);
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (!up && !dn));
endmodule

// File: tb/pfd_antibacklash_bench.sv
module pfd_antibacklash_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_edge = 1'b0;
    logic       fb_edge = 1'b0;
    logic [1:0] ovl_sel = 2'd0;
    logic       up, dn, phase_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfd_antibacklash u_pfd_antibacklash (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
        .ovl_sel(ovl_sel), .up(up), .dn(dn), .phase_err(phase_err)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Episode with one strobe on each side; d = feedback time minus reference time.
    task automatic pair_episode(input int d, input int sel);
        int w = sel + 1;
        int tr = (d >= 0) ? 0 : -d;
        int tf = tr + d;
        int n_up = 0, n_dn = 0, n_err = 0, n_both = 0, n_bad = 0;
        ovl_sel = sel[1:0];
        for (int t = 0; t < 30; t++) begin
            @(negedge clk);
            n_up   += int'(up);
            n_dn   += int'(dn);
            n_err  += int'(phase_err);
            n_both += int'(up && dn);
            if (phase_err != (up ^ dn)) n_bad++;
            ref_edge = (t == tr);
            fb_edge  = (t == tf);
        end
        ref_edge = 1'b0;
        fb_edge  = 1'b0;
        check("R4", n_both, w, $sformatf("overlap d=%0d sel=%0d", d, sel));
        check("R6", n_bad, 0, $sformatf("xor mismatches d=%0d sel=%0d", d, sel));
        if (d == 0) begin
            check("R5", n_up, w, $sformatf("aligned up sel=%0d", sel));
            check("R5", n_err, 0, $sformatf("aligned err sel=%0d", sel));
        end else begin
            check("R8", n_up, (d > 0) ? d + w : w, $sformatf("up cycles d=%0d sel=%0d", d, sel));
            check("R8", n_dn, (d < 0) ? -d + w : w, $sformatf("dn cycles d=%0d sel=%0d", d, sel));
            check("R8", n_err, (d > 0) ? d : -d, $sformatf("err cycles d=%0d sel=%0d", d, sel));
        end
    endtask

    // A reference strobe at t_extra after an aligned pair; returns up seen on the next cycle.
    task automatic extra_strobe(input int sel, input int t_extra, output logic seen);
        seen = 1'b0;
        ovl_sel = sel[1:0];
        for (int t = 0; t < 20; t++) begin
            @(negedge clk);
            if (t == t_extra + 1) seen = up;
            ref_edge = (t == 0) || (t == t_extra);
            fb_edge  = (t == 0);
        end
        ref_edge = 1'b0;
        fb_edge  = 1'b0;
        // A re-armed flag is still waiting for a feedback strobe: release it.
        @(negedge clk); fb_edge = up;
        @(negedge clk); fb_edge = 1'b0;
        for (int t = 0; t < 8; t++) @(negedge clk);
    endtask

    // Steady frequency difference; returns total up and dn cycles.
    task automatic freq_run(input int p_ref, input int p_fb, output int n_up, output int n_dn);
        n_up = 0; n_dn = 0;
        ovl_sel = 2'd0;
        for (int t = 0; t < 600; t++) begin
            @(negedge clk);
            n_up += int'(up);
            n_dn += int'(dn);
            ref_edge = (t % p_ref == 0);
            fb_edge  = (t % p_fb == 0);
        end
        ref_edge = 1'b0;
        fb_edge  = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic seen;
        int a, b;
        repeat (3) @(negedge clk);
        check("R1", int'(up), 0, "up in reset");
        check("R1", int'(dn), 0, "dn in reset");
        check("R1", int'(phase_err), 0, "err in reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2 and R3: single strobes set their flags and hold them.
        ref_edge = 1'b1; @(negedge clk); ref_edge = 1'b0;
        check("R2", int'(up), 1, "up after ref strobe");
        repeat (5) @(negedge clk);
        check("R2", int'(up), 1, "up held");
        check("R3", int'(dn), 0, "dn idle");
        fb_edge = 1'b1; @(negedge clk); fb_edge = 1'b0;
        check("R3", int'(dn), 1, "dn after fb strobe");
        repeat (6) @(negedge clk);
        check("R4", int'(up || dn), 0, "both cleared");

        // R1: reset in the middle of a pulse.
        ref_edge = 1'b1; @(negedge clk); ref_edge = 1'b0;
        rst_n = 1'b0; @(negedge clk);
        check("R1", int'(up), 0, "up after mid-pulse reset");
        check("R1", int'(phase_err), 0, "err after mid-pulse reset");
        rst_n = 1'b1; @(negedge clk);

        // R4, R5, R6, R8: full sweep over codes and lead/lag.
        for (int sel = 0; sel < 4; sel++)
            for (int d = -6; d <= 6; d++)
                pair_episode(d, sel);

        // R7: strobe on the clearing edge is dropped; one edge later re-arms.
        for (int sel = 0; sel < 4; sel++) begin
            extra_strobe(sel, sel + 1, seen);
            check("R7", int'(seen), 0, $sformatf("strobe at clear ignored sel=%0d", sel));
            extra_strobe(sel, sel + 2, seen);
            check("R7", int'(seen), 1, $sformatf("strobe after clear re-arms sel=%0d", sel));
        end

        // R8: frequency difference.
        freq_run(20, 23, a, b);
        check("R8", int'(a > b), 1, $sformatf("faster ref up=%0d dn=%0d", a, b));
        freq_run(23, 20, a, b);
        check("R8", int'(b > a), 1, $sformatf("faster fb up=%0d dn=%0d", a, b));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule